// File: doc/BRIEF.md
# R2 Compelled Handshake Sequencer

This block sits between a two-tone detector, a host command path and a two-tone generator on one signaling channel. It follows whether the far end is currently sending (the link state) and decides cycle by cycle whether the local generator may sound and which tone code it plays. In automatic mode it runs the compelled handshake on its own. Depending on the channel direction and on the link state, a host transmit command either starts at once or is parked in a one-deep pending slot. A later change of the link state then releases or silences it.

In forward direction the generator is free while the far end is quiet, and it is silenced while the far end sends. In backward direction the rule is reversed. Each change of link state produces a one-cycle report toward the host. Entry into the "far signal present" state carries the detected code. Return to quiet can carry an end-of-tone mark. In manual mode only host commands move the generator. A disabled channel freezes all of this, but a tone that is already playing keeps playing.

Top module: `r2_compel_seq`

## Requirements
- R1: After synchronous reset, `tx_on` is 0 and `tx_code` is 0. `rpt_valid` is 0. The link state is quiet and the pending slot is empty.
- R2: In forward direction with automatic mode and a quiet link, a command with a nonzero code sets `tx_on`=1 and `tx_code` to that code on the clock edge that samples it.
- R3: In forward automatic mode, the edge where the link turns to far-signal-present clears `tx_on` and sets `tx_code` to 0. A nonzero command sampled while the link is, or is becoming, far-present is stored as pending. On the edge where the link returns to quiet, a pending code starts to play and the slot empties.
- R4: In backward automatic mode the rules are reversed. A nonzero command on a quiet link becomes pending. The edge entering far-present starts the pending code. A command while far-present starts at once. The edge returning to quiet forces `tx_on`=0.
- R5: If the slot is empty when the link enters the state that permits sending, `tx_on` stays 0.
- R6: One edge after the detector raises `det_present` on an enabled channel, `rpt_valid`=1 for one cycle, with `rpt_end`=0 and `rpt_code` equal to the `det_code` sampled on that edge.
- R7: On the edge where the link returns to quiet, `rpt_valid`=1 with `rpt_end`=1 and `rpt_code`=0 if `cfg_eot_rpt`=1. If `cfg_eot_rpt`=0, there is no report.
- R8: With `cfg_auto`=0, detector changes never alter `tx_on` or `tx_code`. Commands act at once.
- R9: With `cfg_enable`=0, commands and detector input are ignored: the link state is frozen, no report is made, and a tone already playing continues.
- R10: The all-zero command code means tone off. It clears `tx_on`, sets `tx_code` to 0 and empties the pending slot.
- R11: A new nonzero command that arrives while a command is pending replaces the pending code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_forward | input | 1 | 1 = forward direction, 0 = backward |
| cfg_auto | input | 1 | 1 = automatic compelled mode, 0 = manual |
| cfg_eot_rpt | input | 1 | Report end of tone when the link goes quiet |
| det_present | input | 1 | Detector: far-end tone pair present |
| det_code | input | CODE_W | Detector: code of the received pair |
| cmd_valid | input | 1 | Host command strobe, one cycle |
| cmd_code | input | CODE_W | Commanded tone code, zero = tone off |
| tx_on | output | 1 | Generator enable |
| tx_code | output | CODE_W | Code being played, zero while off |
| rpt_valid | output | 1 | One-cycle report strobe toward the host |
| rpt_end | output | 1 | Report is an end-of-tone mark |
| rpt_code | output | CODE_W | Received code carried by the report |

## Verification
Link state and pending slot are not visible directly, so a wrong link state shows up one edge later, either as a missing report or as a report that should not occur. A wrong pending slot only becomes visible when the link next enters its sending state: the generator then starts a stale code or stays silent. For that reason every scenario ends with such a transition, and each expected value is compared on the cycle right after the edge that samples the stimulus.

// File: rtl/r2_seq_pkg.sv
// Package for the compelled sequencer: link state encoding shared by its parts.
package r2_seq_pkg;
    // Link state: far end silent or far end sending.
    typedef enum logic {
        LINK_QUIET = 1'b0,
        LINK_FAR   = 1'b1
    } link_e;
endpackage

// File: rtl/r2_seq_link_track.sv
// Link tracker: follows the detector presence flag while the channel is
// enabled, announces transitions combinationally and registers a one-cycle
// report toward the host. Assumes det_present is already debounced.
module r2_seq_link_track
    import r2_seq_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              eot_rpt,
    input  logic              det_present,
    input  logic [CODE_W-1:0] det_code,
    output link_e             link_nxt,
    output logic              link_change,
    output logic              rpt_valid,
    output logic              rpt_end,
    output logic [CODE_W-1:0] rpt_code
);
    link_e link_q;
    link_e det_state;

    // Map the detector flag to a link state value.
    always_comb det_state = det_present ? LINK_FAR : LINK_QUIET;

    // A transition only counts on an enabled channel.
    always_comb begin
        link_change = enable && (det_state != link_q);
        link_nxt    = link_change ? det_state : link_q;
    end

    // Hold the link state.
    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= LINK_QUIET;
        else        link_q <= link_nxt;
    end

    // Build the report pulse for the transition just taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_valid <= 1'b0;
            rpt_end   <= 1'b0;
            rpt_code  <= '0;
        end else if (link_change && det_state == LINK_FAR) begin
            rpt_valid <= 1'b1;
            rpt_end   <= 1'b0;
            rpt_code  <= det_code;
        end else if (link_change && eot_rpt) begin
            rpt_valid <= 1'b1;
            rpt_end   <= 1'b1;
            rpt_code  <= '0;
        end else begin
            rpt_valid <= 1'b0;
            rpt_end   <= 1'b0;
            rpt_code  <= '0;
        end
    end
endmodule

// File: rtl/r2_seq_pend_slot.sv
// One-deep pending command slot. A load overwrites any older code; a drop
// empties it. The caller never asserts load and drop together.
module r2_seq_pend_slot #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    input  logic              drop,
    output logic              pend_valid,
    output logic [CODE_W-1:0] pend_code
);
    // Store, replace or clear the parked code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_code  <= '0;
        end else if (load) begin
            pend_valid <= 1'b1;
            pend_code  <= load_code;
        end else if (drop) begin
            pend_valid <= 1'b0;
            pend_code  <= '0;
        end
    end
endmodule

// File: rtl/r2_seq_tx_gate.sv
// Transmitter gate: merges host commands with link transitions into the
// generator enable and code. Commands are judged against the link state
// that holds after the current edge. Tone-off outranks everything.
module r2_seq_tx_gate #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              auto_mode,
    input  logic              allowed_nxt,
    input  logic              enter_allowed,
    input  logic              enter_blocked,
    input  logic              pend_valid,
    input  logic [CODE_W-1:0] pend_code,
    output logic              pend_load,
    output logic              pend_drop,
    output logic              tx_on,
    output logic [CODE_W-1:0] tx_code
);
    logic              nxt_on;
    logic [CODE_W-1:0] nxt_code;
    logic              cmd_off;

    // Zero code is the tone-off command.
    always_comb cmd_off = cmd_go && (cmd_code == '0);

    // Decide the next generator state and the slot action.
    always_comb begin
        nxt_on    = tx_on;
        nxt_code  = tx_code;
        pend_load = 1'b0;
        pend_drop = 1'b0;
        if (cmd_off) begin
            nxt_on    = 1'b0;
            nxt_code  = '0;
            pend_drop = 1'b1;
        end else if (cmd_go) begin
            if (!auto_mode || allowed_nxt) begin
                nxt_on    = 1'b1;
                nxt_code  = cmd_code;
                pend_drop = 1'b1;
            end else begin
                pend_load = 1'b1;
                if (enter_blocked) begin
                    nxt_on   = 1'b0;
                    nxt_code = '0;
                end
            end
        end else if (enter_blocked) begin
            nxt_on   = 1'b0;
            nxt_code = '0;
        end else if (enter_allowed && pend_valid) begin
            nxt_on    = 1'b1;
            nxt_code  = pend_code;
            pend_drop = 1'b1;
        end
    end

    // Register the generator controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_on   <= 1'b0;
            tx_code <= '0;
        end else begin
            tx_on   <= nxt_on;
            tx_code <= nxt_code;
        end
    end
endmodule

// File: rtl/r2_compel_seq.sv
// Compelled handshake sequencer for one signaling channel. It ties the link
// tracker, the pending slot and the transmitter gate together and works out
// which link state permits sending for the configured direction. Assumes
// configuration inputs change only between handshakes and that a command
// strobe lasts one cycle.
module r2_compel_seq
    import r2_seq_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_forward,
    input  logic              cfg_auto,
    input  logic              cfg_eot_rpt,
    input  logic              det_present,
    input  logic [CODE_W-1:0] det_code,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    output logic              tx_on,
    output logic [CODE_W-1:0] tx_code,
    output logic              rpt_valid,
    output logic              rpt_end,
    output logic [CODE_W-1:0] rpt_code
);
    link_e             link_nxt;
    logic              link_change;
    logic              allowed_nxt;
    logic              enter_allowed;
    logic              enter_blocked;
    logic              cmd_go;
    logic              pend_load;
    logic              pend_drop;
    logic              pend_valid;
    logic [CODE_W-1:0] pend_code;

    // Forward sends on a quiet link, backward sends while the far end sends.
    always_comb begin
        allowed_nxt   = cfg_forward ? (link_nxt == LINK_QUIET) : (link_nxt == LINK_FAR);
        enter_allowed = cfg_auto && link_change && allowed_nxt;
        enter_blocked = cfg_auto && link_change && !allowed_nxt;
        cmd_go        = cfg_enable && cmd_valid;
    end

    r2_seq_link_track #(.CODE_W(CODE_W)) u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_enable),
        .eot_rpt     (cfg_eot_rpt),
        .det_present (det_present),
        .det_code    (det_code),
        .link_nxt    (link_nxt),
        .link_change (link_change),
        .rpt_valid   (rpt_valid),
        .rpt_end     (rpt_end),
        .rpt_code    (rpt_code)
    );

    r2_seq_pend_slot #(.CODE_W(CODE_W)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pend_load),
        .load_code  (cmd_code),
        .drop       (pend_drop),
        .pend_valid (pend_valid),
        .pend_code  (pend_code)
    );

    r2_seq_tx_gate #(.CODE_W(CODE_W)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_go        (cmd_go),
        .cmd_code      (cmd_code),
        .auto_mode     (cfg_auto),
        .allowed_nxt   (allowed_nxt),
        .enter_allowed (enter_allowed),
        .enter_blocked (enter_blocked),
        .pend_valid    (pend_valid),
        .pend_code     (pend_code),
        .pend_load     (pend_load),
        .pend_drop     (pend_drop),
        .tx_on         (tx_on),
        .tx_code       (tx_code)
    );
endmodule

// File: rtl/r2_compel_seq_chk.sv
// Property checker for the compelled sequencer, attached by bind. Watches
// only the ports of the sequencer.
module r2_compel_seq_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic              cfg_forward,
    input logic              cfg_auto,
    input logic              cmd_valid,
    input logic [CODE_W-1:0] cmd_code,
    input logic              tx_on,
    input logic [CODE_W-1:0] tx_code,
    input logic              rpt_valid,
    input logic              rpt_end,
    input logic [CODE_W-1:0] rpt_code
);
    AST_FWD_FAR_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !rpt_end && $past(cfg_enable && cfg_auto && cfg_forward)) |-> !tx_on); // R3
    AST_BWD_QUIET_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_end && $past(cfg_enable && cfg_auto && !cfg_forward)) |-> !tx_on); // R4
    AST_END_MARK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_end |-> (rpt_valid && rpt_code == '0)); // R7
    AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !cfg_auto && !cmd_valid) |=> ($stable(tx_on) && $stable(tx_code))); // R8
    AST_DISABLED_NO_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !rpt_valid); // R9
    AST_DISABLED_TX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> ($stable(tx_on) && $stable(tx_code))); // R9
    AST_TONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cmd_valid && cmd_code == '0) |=> (!tx_on && tx_code == '0)); // R10
    AST_ON_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_on |-> (tx_code != '0)); // R10
endmodule

bind r2_compel_seq r2_compel_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .cfg_forward (cfg_forward),
    .cfg_auto    (cfg_auto),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .tx_on       (tx_on),
    .tx_code     (tx_code),
    .rpt_valid   (rpt_valid),
    .rpt_end     (rpt_end),
    .rpt_code    (rpt_code)
);

// File: tb/test_r2_compel_seq.sv
// Scoreboard bench: the driver pushes hand-derived expectations, the monitor
// pops and compares them on the falling edge after each sampling edge.
module test_r2_compel_seq;
    localparam int CW = 6;

    typedef struct {
        logic          on;
        logic [CW-1:0] code;
        logic          rv;
        logic          rend;
        logic [CW-1:0] rcode;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b1, cfg_forward = 1'b1, cfg_auto = 1'b1, cfg_eot_rpt = 1'b1;
    logic          det_present = 1'b0;
    logic [CW-1:0] det_code = '0;
    logic          cmd_valid = 1'b0;
    logic [CW-1:0] cmd_code = '0;
    logic          tx_on, rpt_valid, rpt_end;
    logic [CW-1:0] tx_code, rpt_code;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    r2_compel_seq #(.CODE_W(CW)) i_r2_compel_seq (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_forward(cfg_forward),
        .cfg_auto(cfg_auto), .cfg_eot_rpt(cfg_eot_rpt), .det_present(det_present),
        .det_code(det_code), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .tx_on(tx_on), .tx_code(tx_code), .rpt_valid(rpt_valid), .rpt_end(rpt_end),
        .rpt_code(rpt_code)
    );

    // Monitor: compare the outputs with the oldest expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (tx_on !== e.on || tx_code !== e.code || rpt_valid !== e.rv ||
                rpt_end !== e.rend || rpt_code !== e.rcode) begin
                n_bad++;
                $display("FAIL %s: got on=%b code=%h rv=%b end=%b rcode=%h, expected on=%b code=%h rv=%b end=%b rcode=%h",
                         e.tag, tx_on, tx_code, rpt_valid, rpt_end, rpt_code,
                         e.on, e.code, e.rv, e.rend, e.rcode);
            end
        end
    end

    // Driver: apply one cycle of stimulus and queue what must follow.
    task automatic step(input logic det, input logic [CW-1:0] dcode,
                        input logic cv, input logic [CW-1:0] ccode,
                        input logic e_on, input logic [CW-1:0] e_code,
                        input logic e_rv, input logic e_rend, input logic [CW-1:0] e_rcode,
                        input string tag);
        exp_t e;
        @(negedge clk);
        det_present = det;
        det_code    = dcode;
        cmd_valid   = cv;
        cmd_code    = ccode;
        @(posedge clk);
        #1;
        e.on = e_on; e.code = e_code; e.rv = e_rv; e.rend = e_rend; e.rcode = e_rcode; e.tag = tag;
        exp_q.push_back(e);
        cmd_valid = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (tx_on !== 1'b0 || tx_code !== '0 || rpt_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got on=%b code=%h rv=%b, expected 0 0 0", tx_on, tx_code, rpt_valid);
        end
        rst_n = 1'b1;
        // Forward, automatic, end-of-tone reports on
        step(0, 6'h00, 1, 6'h03, 1, 6'h03, 0, 0, 6'h00, "R2");
        step(1, 6'h05, 0, 6'h00, 0, 6'h00, 1, 0, 6'h05, "R3/R6");
        step(1, 6'h05, 1, 6'h06, 0, 6'h00, 0, 0, 6'h00, "R3");
        step(1, 6'h05, 1, 6'h0A, 0, 6'h00, 0, 0, 6'h00, "R11");
        step(0, 6'h00, 0, 6'h00, 1, 6'h0A, 1, 1, 6'h00, "R3/R7");
        step(0, 6'h00, 1, 6'h00, 0, 6'h00, 0, 0, 6'h00, "R10");
        step(1, 6'h11, 0, 6'h00, 0, 6'h00, 1, 0, 6'h11, "R6");
        step(0, 6'h00, 0, 6'h00, 0, 6'h00, 1, 1, 6'h00, "R5");
        cfg_eot_rpt = 1'b0;
        step(1, 6'h12, 0, 6'h00, 0, 6'h00, 1, 0, 6'h12, "R6");
        step(0, 6'h00, 0, 6'h00, 0, 6'h00, 0, 0, 6'h00, "R7");
        step(1, 6'h14, 1, 6'h05, 0, 6'h00, 1, 0, 6'h14, "R3");
        step(1, 6'h14, 1, 6'h00, 0, 6'h00, 0, 0, 6'h00, "R10");
        step(0, 6'h00, 0, 6'h00, 0, 6'h00, 0, 0, 6'h00, "R10");
        // Backward, automatic, end-of-tone reports on
        cfg_forward = 1'b0;
        cfg_eot_rpt = 1'b1;
        step(0, 6'h00, 1, 6'h21, 0, 6'h00, 0, 0, 6'h00, "R4");
        step(1, 6'h03, 0, 6'h00, 1, 6'h21, 1, 0, 6'h03, "R4");
        step(1, 6'h03, 1, 6'h22, 1, 6'h22, 0, 0, 6'h00, "R4");
        step(0, 6'h00, 0, 6'h00, 0, 6'h00, 1, 1, 6'h00, "R4");
        step(1, 6'h09, 0, 6'h00, 0, 6'h00, 1, 0, 6'h09, "R5");
        step(0, 6'h00, 0, 6'h00, 0, 6'h00, 1, 1, 6'h00, "R4");
        // Manual mode
        cfg_auto = 1'b0;
        step(0, 6'h00, 1, 6'h07, 1, 6'h07, 0, 0, 6'h00, "R8");
        step(1, 6'h09, 0, 6'h00, 1, 6'h07, 1, 0, 6'h09, "R8");
        step(0, 6'h00, 0, 6'h00, 1, 6'h07, 1, 1, 6'h00, "R8");
        // Disabled channel with a tone still playing
        cfg_enable = 1'b0;
        step(1, 6'h09, 1, 6'h00, 1, 6'h07, 0, 0, 6'h00, "R9");
        step(0, 6'h00, 1, 6'h11, 1, 6'h07, 0, 0, 6'h00, "R9");
        step(1, 6'h0C, 0, 6'h00, 1, 6'h07, 0, 0, 6'h00, "R9");
        // Re-enabled: backward automatic, link was frozen quiet
        cfg_enable = 1'b1;
        cfg_auto   = 1'b1;
        det_present = 1'b0;
        step(0, 6'h00, 1, 6'h00, 0, 6'h00, 0, 0, 6'h00, "R10");
        step(1, 6'h2A, 0, 6'h00, 0, 6'h00, 1, 0, 6'h2A, "R9");
        @(negedge clk);
        @(negedge clk);
        summary();
    end
endmodule